// File: doc/BRIEF.md
# I2C Bus Line Override and Reset Control

This block is the first control register of an I2C controller together with the pin logic behind it. Software uses it to switch the controller on and off and to hold the transfer engine in an internal reset while the other configuration registers are set up. It also uses it to drive SCL and SDA by hand when a bus has to be recovered. The block brings both bus lines in through two-flop synchronisers and shows their levels in the register. Software can therefore see a line that is stuck low even when no transfer is in progress.

Each bus pin is open-drain. The block outputs one active-high pull-low enable per line. A line is pulled low when the controller is enabled and either its manual output bit is 0 or the transfer engine asks for a low. A bus-busy flag follows START and STOP conditions seen on the synchronised lines.

To bring the controller up, software first sets the internal reset bit, then sets the enable bit, then programs the other registers, and finally clears the internal reset bit. The engine stays idle through this sequence. The manual line bits have a write guard. They change only in a write that has the guard bit at 0, so a write that touches only enable or internal reset cannot disturb the lines by accident.

Top module: `i2c_line_ctrl`

## Requirements
- R1: Read data layout is: bit 7 enable, bit 6 internal reset, bit 5 reads 0, bit 4 reads 1, bit 3 manual SCL output, bit 2 manual SDA output, bit 1 SCL level, bit 0 SDA level. The levels are the pin values sampled two clock edges earlier.
- R2: Every write loads bits 7 and 6. Bits 3 and 2 are loaded only when bit 4 of the write data is 0. A write with bit 4 at 1 leaves bits 3 and 2 unchanged.
- R3: While enable is 0, neither scl_oe_o nor sda_oe_o is asserted, whatever the manual bits or the engine requests are.
- R4: While enable is 1, a line's pull-low enable is 1 when its manual bit is 0 or the engine requests a low on that line. Otherwise it is 0.
- R5: eng_rst_o equals the internal reset bit. While that bit is 1, the engine's low requests are ignored. Enable and the manual bits keep their values through the internal reset.
- R6: bus_busy_o sets on the clock edge after the synchronised SDA falls while the synchronised SCL is high on both samples.
- R7: bus_busy_o clears on the clock edge after the synchronised SDA rises while the synchronised SCL is high on both samples.
- R8: While the internal reset bit is 1, bus_busy_o is cleared and held at 0. A START seen on the same edge that sets the bit still sets the flag for one cycle.
- R9: After rst_ni, the register reads 8'h1F with both lines high, bus_busy_o is 0, and eng_rst_o is 0.
- R10: SDA falling while SCL is low does not set bus_busy_o. The low level is still shown in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register read data |
| scl_i | input | 1 | SCL pin level |
| sda_i | input | 1 | SDA pin level |
| eng_scl_low_i | input | 1 | Engine request to pull SCL low |
| eng_sda_low_i | input | 1 | Engine request to pull SDA low |
| scl_oe_o | output | 1 | Pull SCL low |
| sda_oe_o | output | 1 | Pull SDA low |
| eng_rst_o | output | 1 | Holds the transfer engine in reset |
| bus_busy_o | output | 1 | Bus busy between START and STOP |

## Verification
Two functions can act on the same clock edge. One is a register write that sets the internal reset bit. The other is a START condition reaching the end of the synchroniser. The bench schedules the write so that it lands on exactly the edge where the synchronised SDA falls. It then expects bus_busy_o to be 1 for one cycle and to be held at 0 after that. A second case pairs a guarded write, which is meant to leave the manual bits alone, with an engine low request on the same line. The bench checks that the pull-low enable follows only the engine.

// File: rtl/i2c_lc_pkg.sv
package i2c_lc_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned B_EN    = 7;
  localparam int unsigned B_IRST  = 6;
  localparam int unsigned B_RSVD  = 5;
  localparam int unsigned B_WP    = 4;
  localparam int unsigned B_SCLM  = 3;
  localparam int unsigned B_SDAM  = 2;
  localparam int unsigned B_SCLL  = 1;
  localparam int unsigned B_SDAL  = 0;
  localparam int unsigned N_LINES = 2;
  localparam int unsigned L_SDA   = 0;
  localparam int unsigned L_SCL   = 1;
endpackage

// File: rtl/i2c_lc_sync.sv
module i2c_lc_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain <= '1;
      else         chain <= {chain[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/i2c_lc_busy.sv
module i2c_lc_busy (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  input  logic hold_clr_i,
  output logic busy_o
);
  logic scl_p, sda_p, start_c, stop_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s_i;
      sda_p <= sda_s_i;
    end
  end

  assign start_c = scl_p & scl_s_i & sda_p & ~sda_s_i;
  assign stop_c  = scl_p & scl_s_i & ~sda_p & sda_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        busy_o <= 1'b0;
    else if (hold_clr_i) busy_o <= 1'b0;
    else if (start_c)    busy_o <= 1'b1;
    else if (stop_c)     busy_o <= 1'b0;
  end

  p_start_sets_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_c && !hold_clr_i) |=> busy_o);
  p_stop_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_c |=> !busy_o);
  p_irst_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_clr_i |=> !busy_o);
  p_no_start_no_rise_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_c && !busy_o) |=> !busy_o);
endmodule

// File: rtl/i2c_lc_regs.sv
module i2c_lc_regs
  import i2c_lc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic             en_o,
  output logic             irst_o,
  output logic             scl_man_o,
  output logic             sda_man_o
);
  logic wp_open;
  assign wp_open = wr_en_i & ~wr_data_i[B_WP];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= 1'b0;
      irst_o <= 1'b0;
    end else if (wr_en_i) begin
      en_o   <= wr_data_i[B_EN];
      irst_o <= wr_data_i[B_IRST];
    end
  end

  // manual line bits only move when the guard bit is written as 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_man_o <= 1'b1;
      sda_man_o <= 1'b1;
    end else if (wp_open) begin
      scl_man_o <= wr_data_i[B_SCLM];
      sda_man_o <= wr_data_i[B_SDAM];
    end
  end

  p_wp_holds_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[B_WP]) |=> ($stable(scl_man_o) && $stable(sda_man_o)));
  p_no_write_holds_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(en_o) && $stable(irst_o)));
endmodule

// File: rtl/i2c_line_ctrl.sv
module i2c_line_ctrl
  import i2c_lc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             eng_scl_low_i,
  input  logic             eng_sda_low_i,
  output logic             scl_oe_o,
  output logic             sda_oe_o,
  output logic             eng_rst_o,
  output logic             bus_busy_o
);
  logic en, irst, scl_man, sda_man;
  logic [N_LINES-1:0] pin_raw, pin_s;

  i2c_lc_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .en_o      (en),
    .irst_o    (irst),
    .scl_man_o (scl_man),
    .sda_man_o (sda_man)
  );

  assign pin_raw[L_SCL] = scl_i;
  assign pin_raw[L_SDA] = sda_i;

  i2c_lc_sync #(.WIDTH(N_LINES), .STAGES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_raw),
    .q_o    (pin_s)
  );

  i2c_lc_busy u_busy (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_s_i    (pin_s[L_SCL]),
    .sda_s_i    (pin_s[L_SDA]),
    .hold_clr_i (irst),
    .busy_o     (bus_busy_o)
  );

  // engine requests are void while it is held in reset
  assign scl_oe_o  = en & (~scl_man | (eng_scl_low_i & ~irst));
  assign sda_oe_o  = en & (~sda_man | (eng_sda_low_i & ~irst));
  assign eng_rst_o = irst;

  always_comb begin
    rd_data_o         = '0;
    rd_data_o[B_EN]   = en;
    rd_data_o[B_IRST] = irst;
    rd_data_o[B_RSVD] = 1'b0;
    rd_data_o[B_WP]   = 1'b1;
    rd_data_o[B_SCLM] = scl_man;
    rd_data_o[B_SDAM] = sda_man;
    rd_data_o[B_SCLL] = pin_s[L_SCL];
    rd_data_o[B_SDAL] = pin_s[L_SDA];
  end

  p_off_no_drive_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_data_o[B_EN] |-> (!scl_oe_o && !sda_oe_o));
  p_irst_mask_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_rst_o && rd_data_o[B_SCLM]) |-> !scl_oe_o);
endmodule

// File: tb/i2c_line_ctrl_tb.sv
module i2c_line_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic scl = 1'b1, sda = 1'b1, e_scl = 1'b0, e_sda = 1'b0;
  logic [7:0] rd_data;
  logic scl_oe, sda_oe, eng_rst, busy;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  // reference model
  bit m_en, m_irst, m_sclm, m_sdam, m_busy;
  bit h_scl[$], h_sda[$];

  always #2.5 clk = ~clk;

  i2c_line_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .scl_i(scl), .sda_i(sda),
    .eng_scl_low_i(e_scl), .eng_sda_low_i(e_sda),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .eng_rst_o(eng_rst), .bus_busy_o(busy)
  );

  task automatic model_reset();
    m_en = 0; m_irst = 0; m_sclm = 1; m_sdam = 1; m_busy = 0;
    h_scl = {1'b1, 1'b1, 1'b1, 1'b1};
    h_sda = {1'b1, 1'b1, 1'b1, 1'b1};
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (rst_n) begin
      h_scl.push_front(scl); h_sda.push_front(sda);
      void'(h_scl.pop_back()); void'(h_sda.pop_back());
      // busy judged on samples from 2 and 3 edges back, with old irst
      if (m_irst) m_busy = 0;
      else if (h_scl[2] && h_scl[3] && h_sda[3] && !h_sda[2]) m_busy = 1;
      else if (h_scl[2] && h_scl[3] && !h_sda[3] && h_sda[2]) m_busy = 0;
      if (wr_en) begin
        m_en = wr_data[7]; m_irst = wr_data[6];
        if (!wr_data[4]) begin m_sclm = wr_data[3]; m_sdam = wr_data[2]; end
      end
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s cyc=%0d actual=%h expected=%h", req, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      chk("R1 R2 R9 R10 rd_data", rd_data,
          {m_en, m_irst, 1'b0, 1'b1, m_sclm, m_sdam, h_scl[1], h_sda[1]});
      chk("R3 R4 R5 scl_oe", {7'd0, scl_oe}, {7'd0, m_en & (!m_sclm | (e_scl & !m_irst))});
      chk("R3 R4 R5 sda_oe", {7'd0, sda_oe}, {7'd0, m_en & (!m_sdam | (e_sda & !m_irst))});
      chk("R5 eng_rst", {7'd0, eng_rst}, {7'd0, m_irst});
      chk("R6 R7 R8 bus_busy", {7'd0, busy}, {7'd0, m_busy});
    end
  end

  task automatic step(int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1; wr_data = d; step(); wr_en = 0;
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
      end
      begin
        step(3); rst_n = 1; step(3);                 // R9 reset state
        wr(8'h4C); step(2);                          // R5 irst, enable still 0
        e_scl = 1; e_sda = 1; step(2);               // R3 no drive while off
        wr(8'hCC); step(2);                          // enable in reset, R5 mask
        wr(8'h80 | 8'h0C); step(2);                  // release reset, R4 engine drives
        e_scl = 0; e_sda = 0; step(1);
        wr(8'h84); step(2);                          // R2 manual SCL low
        wr(8'h98); step(2);                          // R2 guarded write, no change
        wr(8'h9C); e_sda = 1; step(2);               // guarded + engine SDA low
        e_sda = 0; wr(8'h8C); step(2);
        sda = 0; step(6);                            // R6 START
        sda = 1; step(6);                            // R7 STOP
        scl = 0; step(2); sda = 0; step(3);          // R10 no START with SCL low
        scl = 1; step(6);                            // SDA held low, busy clear
        sda = 1; step(4);
        sda = 0; step(5); wr(8'hCC); step(4);        // R8 irst clears busy
        wr(8'h8C); sda = 1; step(6);
        // same edge: START reaches sync end as irst write lands (R8)
        sda = 0; step(2); wr(8'hCC); step(5);
        wr(8'h8C); step(3);
        sda = 1; step(4);
        wr(8'h0C); e_scl = 1; step(3);               // R3 disabled again
        wr(8'h00); step(3);                          // manual 0, still off
      end
    join_any
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule